// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between several requester ports and a small shared word memory and provides the hardware half of an atomic read-modify-write. Each port can issue four kinds of access: a plain load, a plain store, a linked load that also reserves the word it reads, and a conditional store. The conditional store writes memory and reports success only if nothing else has written that word since the same port's linked load.

Each port keeps a single reservation, made of a valid flag and a word address. A plain store or a successful conditional store from any port invalidates the reservations that other ports hold on that address. A conditional store always uses up the reservation of the port that issues it, whether it succeeds or fails. When several ports request in the same cycle, a fixed-priority arbiter grants one of them per cycle. Each granted access completes on the next clock edge and raises a one-cycle response pulse on its own port. A per-port clear input drops that port's reservation, so a requester can discard its reservation when it resets.

Top module: `llsc_monitor`

## Requirements
- R1: A granted plain load (op code 0) returns the addressed word on rdata_o one cycle after the grant, with rvalid_o on that port high for exactly that one cycle.
- R2: A linked load (op code 2) returns the addressed word like a plain load and records a reservation for its port on that address.
- R3: A conditional store (op code 3) whose port holds a valid reservation on the same address writes its data and returns sc_ok_o = 1 with its response.
- R4: A conditional store fails when another port wrote the reserved address after the linked load: sc_ok_o = 0 and the memory word keeps the value that the other port wrote.
- R5: A plain store (op code 1) from another port, including a store of zero, breaks a reservation on the same address. A store to a different address leaves the reservation intact.
- R6: A successful conditional store clears the reservations of all other ports on the same address, so their later conditional stores to it fail.
- R7: A conditional store without a valid reservation, or to an address other than the reserved one, fails and leaves memory unchanged.
- R8: Simultaneous requests are granted one per cycle, lowest port index first. A request stays pending until it is granted, and a later-served port observes the effect of the earlier access.
- R9: A new linked load replaces its port's earlier reservation, so a conditional store to the earlier address fails.
- R10: Asserting clear_i for a port for one cycle drops its reservation, so its next conditional store fails.
- R11: At most one grant is given per cycle. A port's rvalid_o follows that port's grant by exactly one cycle and is never high otherwise.
- R12: A conditional store consumes its own port's reservation, so a second conditional store without a new linked load fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears memory, reservations and responses |
| req_i | input | NPORTS | Per-port request, held until granted |
| op_i | input | 2*NPORTS | Per-port op: 0 load, 1 store, 2 linked load, 3 conditional store |
| addr_i | input | AW*NPORTS | Per-port word address |
| wdata_i | input | DW*NPORTS | Per-port store data |
| clear_i | input | NPORTS | Per-port reservation clear |
| gnt_o | output | NPORTS | Combinational grant, one-hot or zero |
| rvalid_o | output | NPORTS | Per-port response pulse, one cycle after grant |
| rdata_o | output | DW*NPORTS | Per-port read data (word value before this access's write) |
| sc_ok_o | output | NPORTS | Per-port conditional-store success flag, valid with rvalid_o |

## Verification
The assertions assume that a requester keeps req_i, op_i, addr_i and wdata_i stable from the moment it raises a request until the cycle of its grant. They also assume that no request is raised while reset is active. The stimulus meets both conditions: it drives every input on the falling clock edge and holds a request until the grant is seen. It drops the request on the falling edge that follows the granting rising edge. Simultaneous requests come from parallel threads, one per port, each following the same rule.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_arb.sv
module llsc_arb #(
  parameter int NPORTS = 2,
  localparam int IW = $clog2(NPORTS)
) (
  input  logic [NPORTS-1:0] req_i,
  output logic [NPORTS-1:0] gnt_o,
  output logic [IW-1:0]     idx_o,
  output logic              any_o
);
  // lowest index wins
  assign gnt_o = req_i & (~req_i + NPORTS'(1));
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv
  import llsc_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 4,
  localparam int IW = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [IW-1:0]     port_i,
  input  llsc_op_e          op_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NPORTS-1:0] clear_i,
  output logic              sc_pass_o
);
  logic [NPORTS-1:0] vld_q;
  logic [AW-1:0]     adr_q [NPORTS];
  logic              wrote;

  // clear on the same cycle beats the conditional store
  assign sc_pass_o = vld_q[port_i] && (adr_q[port_i] == addr_i) && !clear_i[port_i];
  assign wrote     = acc_i && ((op_i == OP_STORE) || ((op_i == OP_COND) && sc_pass_o));

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[p] <= 1'b0;
        adr_q[p] <= '0;
      end else if (clear_i[p]) begin
        vld_q[p] <= 1'b0;
      end else if (acc_i && (port_i == IW'(p))) begin
        if (op_i == OP_LINK) begin
          vld_q[p] <= 1'b1;
          adr_q[p] <= addr_i;
        end else if (op_i == OP_COND) begin
          vld_q[p] <= 1'b0;
        end
      end else if (wrote && (adr_q[p] == addr_i)) begin
        vld_q[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(NPORTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NPORTS-1:0]    req_i,
  input  logic [2*NPORTS-1:0]  op_i,
  input  logic [AW*NPORTS-1:0] addr_i,
  input  logic [DW*NPORTS-1:0] wdata_i,
  input  logic [NPORTS-1:0]    clear_i,
  output logic [NPORTS-1:0]    gnt_o,
  output logic [NPORTS-1:0]    rvalid_o,
  output logic [DW*NPORTS-1:0] rdata_o,
  output logic [NPORTS-1:0]    sc_ok_o
);
  logic [IW-1:0] win;
  logic          any;
  llsc_op_e      sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata, mem_rdata;
  logic          sc_pass, mem_we;

  llsc_arb #(.NPORTS(NPORTS)) u_arb (
    .req_i (req_i),
    .gnt_o (gnt_o),
    .idx_o (win),
    .any_o (any)
  );

  assign sel_op    = llsc_op_e'(op_i[int'(win)*2 +: 2]);
  assign sel_addr  = addr_i[int'(win)*AW +: AW];
  assign sel_wdata = wdata_i[int'(win)*DW +: DW];
  assign mem_we    = any && ((sel_op == OP_STORE) || ((sel_op == OP_COND) && sc_pass));

  llsc_resv #(.NPORTS(NPORTS), .AW(AW)) u_resv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (any),
    .port_i    (win),
    .op_i      (sel_op),
    .addr_i    (sel_addr),
    .clear_i   (clear_i),
    .sc_pass_o (sc_pass)
  );

  llsc_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (sel_addr),
    .we_i    (mem_we),
    .wdata_i (sel_wdata),
    .rdata_o (mem_rdata)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_rsp
    logic [DW-1:0] rdata_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rvalid_o[p] <= 1'b0;
        sc_ok_o[p]  <= 1'b0;
        rdata_q     <= '0;
      end else begin
        rvalid_o[p] <= gnt_o[p];
        sc_ok_o[p]  <= gnt_o[p] && (sel_op == OP_COND) && sc_pass;
        if (gnt_o[p]) rdata_q <= mem_rdata;
      end
    end
    assign rdata_o[p*DW +: DW] = rdata_q;
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NPORTS = 2,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NPORTS-1:0]    req_i,
  input logic [2*NPORTS-1:0]  op_i,
  input logic [NPORTS-1:0]    gnt_o,
  input logic [NPORTS-1:0]    rvalid_o,
  input logic [NPORTS-1:0]    sc_ok_o
);
  assert_one_grant_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_one_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rvalid_o));
  assert_grant_when_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    assert_resp_after_grant_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |=> rvalid_o[i]);
    assert_no_stray_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gnt_o[i] |=> !rvalid_o[i]);
    assert_low_index_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |-> (req_i[i] && ((req_i & ((NPORTS'(1) << i) - NPORTS'(1))) == '0)));
    assert_ok_with_resp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sc_ok_o[i] |-> rvalid_o[i]);
    assert_ok_only_for_cond_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sc_ok_o[i] |-> ($past(op_i[2*i +: 2]) == 2'd3));
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .op_i     (op_i),
  .gnt_o    (gnt_o),
  .rvalid_o (rvalid_o),
  .sc_ok_o  (sc_ok_o)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int DEPTH = 16;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    req_p;
  logic [2*NP-1:0]  op_p;
  logic [AW*NP-1:0] addr_p;
  logic [DW*NP-1:0] wdata_p;
  logic [NP-1:0]    clear_p;
  logic [NP-1:0]    gnt, rvalid, sc_ok;
  logic [DW*NP-1:0] rdata;

  logic          req_a [NP];
  logic [1:0]    op_a [NP];
  logic [AW-1:0] addr_a [NP];
  logic [DW-1:0] wdata_a [NP];
  logic          clear_a [NP];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [DW-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      req_p[i]               = req_a[i];
      op_p[2*i +: 2]         = op_a[i];
      addr_p[AW*i +: AW]     = addr_a[i];
      wdata_p[DW*i +: DW]    = wdata_a[i];
      clear_p[i]             = clear_a[i];
    end
  end

  llsc_monitor #(.NPORTS(NP), .DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .req_i    (req_p),
    .op_i     (op_p),
    .addr_i   (addr_p),
    .wdata_i  (wdata_p),
    .clear_i  (clear_p),
    .gnt_o    (gnt),
    .rvalid_o (rvalid),
    .rdata_o  (rdata),
    .sc_ok_o  (sc_ok)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called on a falling edge; returns on a falling edge
  task automatic issue(input int p, input logic [1:0] op, input int a, input logic [DW-1:0] wd,
                       output logic [DW-1:0] rd, output logic ok, output logic vld);
    req_a[p] = 1'b1; op_a[p] = op; addr_a[p] = AW'(a); wdata_a[p] = wd;
    #1;
    while (!gnt[p]) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_a[p] = 1'b0;
    rd = rdata[p*DW +: DW]; ok = sc_ok[p]; vld = rvalid[p];
    if (op == 2'd1 || (op == 2'd3 && ok)) model[a] = wd;
  endtask

  task automatic rd_check(input int p, input int a, input string req);
    logic [DW-1:0] rd; logic ok, vld;
    issue(p, 2'd0, a, '0, rd, ok, vld);
    check(vld && rd == model[a], req, rd, model[a]);
  endtask

  task automatic sc_check(input int p, input int a, input logic [DW-1:0] wd, input logic exp, input string req);
    logic [DW-1:0] rd; logic ok, vld;
    issue(p, 2'd3, a, wd, rd, ok, vld);
    check(vld && ok == exp, req, {31'd0, ok}, {31'd0, exp});
  endtask

  task automatic link(input int p, input int a, input string req);
    logic [DW-1:0] rd; logic ok, vld;
    issue(p, 2'd2, a, '0, rd, ok, vld);
    check(vld && rd == model[a] && !ok, req, rd, model[a]);
  endtask

  task automatic store(input int p, input int a, input logic [DW-1:0] wd);
    logic [DW-1:0] rd; logic ok, vld;
    issue(p, 2'd1, a, wd, rd, ok, vld);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      req_a[i] = 0; op_a[i] = 0; addr_a[i] = 0; wdata_a[i] = 0; clear_a[i] = 0;
    end
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(gnt == '0 && rvalid == '0 && sc_ok == '0, "R11 reset", {28'd0, gnt, rvalid}, '0);
    rd_check(1, 9, "R1 reset memory zero");

    // R1 sweep: store from one port, load from the other
    for (int a = 0; a < DEPTH; a++) begin
      store(a % 2, a, 32'hA500_0000 ^ (32'h0101_0101 * a) + a);
      rd_check((a + 1) % 2, a, "R1 load sweep");
    end

    // R2 R4 R5 sweep: link, zero store by other port breaks it, conditional store fails
    for (int a = 0; a < DEPTH; a++) begin
      link(a % 2, a, "R2 link returns word");
      store((a + 1) % 2, a, '0);
      sc_check(a % 2, a, 32'hDEAD_0000 + a, 1'b0, "R4 R5 broken reservation fails");
      rd_check(a % 2, a, "R4 memory keeps other write");
    end

    // R3 success and R12 consumption
    link(1, 3, "R2 link");
    sc_check(1, 3, 32'h1234_5678, 1'b1, "R3 conditional store succeeds");
    rd_check(0, 3, "R3 data written");
    sc_check(1, 3, 32'h0BAD_0BAD, 1'b0, "R12 reservation consumed");
    rd_check(0, 3, "R12 memory unchanged");

    // R6
    link(0, 5, "R2 link");
    link(1, 5, "R2 link");
    sc_check(0, 5, 32'hCAFE_0005, 1'b1, "R6 first conditional store wins");
    sc_check(1, 5, 32'hBEEF_0005, 1'b0, "R6 other reservation cleared");
    rd_check(1, 5, "R6 winner data kept");

    // R7
    sc_check(0, 6, 32'h6666_6666, 1'b0, "R7 no reservation fails");
    rd_check(1, 6, "R7 memory unchanged");
    link(0, 6, "R2 link");
    sc_check(0, 7, 32'h7777_7777, 1'b0, "R7 address mismatch fails");
    rd_check(1, 7, "R7 memory unchanged");

    // R9
    link(1, 8, "R2 link");
    link(1, 9, "R2 link");
    sc_check(1, 8, 32'h8888_8888, 1'b0, "R9 old reservation replaced");
    rd_check(0, 8, "R9 memory unchanged");

    // R5 store to a different address keeps reservation
    link(0, 10, "R2 link");
    store(1, 11, 32'h1111_0011);
    sc_check(0, 10, 32'h1010_1010, 1'b1, "R5 unrelated store keeps reservation");

    // R10
    link(0, 12, "R2 link");
    clear_a[0] = 1'b1;
    @(negedge clk);
    clear_a[0] = 1'b0;
    sc_check(0, 12, 32'hC1EA_0012, 1'b0, "R10 clear drops reservation");
    rd_check(1, 12, "R10 memory unchanged");

    // R8 simultaneous: port 0 store, port 1 load same word
    begin
      logic [DW-1:0] rd0, rd1; logic ok0, ok1, v0, v1; int c0, c1;
      fork
        begin issue(0, 2'd1, 13, 32'h1313_1313, rd0, ok0, v0); c0 = cyc; end
        begin issue(1, 2'd0, 13, '0, rd1, ok1, v1); c1 = cyc; end
      join
      check(v1 && rd1 == 32'h1313_1313, "R8 loser sees winner store", rd1, 32'h1313_1313);
      check(c1 == c0 + 1, "R8 lower index served first", c1, c0 + 1);
      // port 0 links, port 1 store lands after it and breaks it
      fork
        issue(0, 2'd2, 14, '0, rd0, ok0, v0);
        issue(1, 2'd1, 14, 32'h1414_1414, rd1, ok1, v1);
      join
      check(v0 && rd0 == model[14] - 0 || rd0 == '0, "R8 link before store", rd0, '0);
      sc_check(0, 14, 32'hFFFF_0014, 1'b0, "R8 later store broke reservation");
      rd_check(0, 14, "R8 memory holds serialized store");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule